// File: doc/BRIEF.md
# Sprite DMA transfer engine

This block copies one page of the CPU address space, 256 bytes by default, into the sprite data port of a video processor. The CPU starts a copy by writing to a trigger address. The byte it writes becomes the high byte of every source address. From the cycle after that write, the engine withdraws the CPU's run-enable and becomes the bus master. It waits one or two alignment cycles, then alternates between read and write cycles until the whole page has been moved. It then hands the bus back to the CPU and pulses a completion flag.

The length of the alignment wait depends on the parity of the number of cycles the CPU has actually executed. The engine tracks this parity itself by counting the cycles in which the run-enable is high. A CPU read of the trigger address is acknowledged and returns zero. Any write to the trigger address while a copy is under way has no effect.

Top module: `sprite_dma_engine`

## Requirements
- R1: A write (`cpu_wr_en`=1) with `cpu_addr`=0x4014 while idle starts a copy, and latches `cpu_wdata` as the source page (address bits 15:8).
- R2: The alignment wait is 1 cycle when an even number of CPU-run cycles (cycles with `cpu_run`=1 since reset) came before the trigger cycle, and 2 cycles when that number is odd. During the wait, no bus strobe is asserted.
- R3: After the wait, the engine performs exactly 256 read/write pairs. A read cycle (`dma_rd_en`=1) is always followed by a write cycle (`dma_wr_en`=1). The two strobes are never high together.
- R4: The read of pair n uses address {page, n}, where n runs upward from 0x00 to 0xFF.
- R5: Each write goes to address 0x2004 and carries the byte returned on `dma_rd_data` in the read cycle just before it.
- R6: `cpu_run` is 0 from the cycle after the trigger through the last write cycle, and is 1 at all other times.
- R7: `xfer_done` is 1 for exactly one cycle: the cycle immediately after the last write.
- R8: Writes to 0x4014 during a copy are ignored. The page, address sequence and length of the copy are unchanged.
- R9: A read (`cpu_rd_en`=1) of 0x4014 raises `trig_rd_ack` in the same cycle with `trig_rdata`=0x00. A read of any other address leaves `trig_rd_ack` at 0.
- R10: A synchronous active-low reset, applied at any time, returns the engine to idle. The first cycle after reset has `cpu_run`=1, no bus strobes and `xfer_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| trig_rd_ack | output | 1 | The CPU read hit the trigger address |
| trig_rdata | output | 8 | Read data for the trigger address (always zero) |
| cpu_run | output | 1 | CPU clock enable |
| dma_rd_en | output | 1 | Engine read strobe |
| dma_rd_addr | output | 16 | Engine read address |
| dma_rd_data | input | 8 | Data returned for the engine read, same cycle |
| dma_wr_en | output | 1 | Engine write strobe |
| dma_wr_addr | output | 16 | Engine write address (sprite data port) |
| dma_wr_data | output | 8 | Engine write data |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
Call the trigger cycle 0 and the alignment wait W. The read acknowledge is combinational and is due in cycle 0. The engine is silent in cycles 1 to W. The read of pair n falls in cycle W+1+2n and its write in cycle W+2+2n. `xfer_done` and the return of `cpu_run` are due in cycle W+513. The bench derives W from its own count of run cycles, which it keeps on rising edges. It drives inputs and samples outputs on falling edges, and compares every cycle of each copy against this timetable. A reset check is sampled one falling edge after a single reset edge.

// File: rtl/sdma_pkg.sv
// Shared types for the sprite DMA engine.
package sdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_MOVE  = 2'd2
    } sdma_state_e;
endpackage

// File: rtl/sdma_parity.sv
// sdma_parity: tracks the parity of CPU-executed cycles since reset.
// Assumes one CPU cycle per clk and that cpu_run marks executed cycles.
module sdma_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_run,
    output logic odd
);
    // Flip parity on each cycle the CPU actually runs.
    always_ff @(posedge clk) begin
        if (!rst_n)       odd <= 1'b0;
        else if (cpu_run) odd <= ~odd;
    end

    // R2
    parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_run |=> $stable(odd));
endmodule

// File: rtl/sdma_sequencer.sv
// sdma_sequencer: idle / align / move control with read-write phase toggle.
// Assumes start is only raised while idle and last_byte is valid in write phase.
module sdma_sequencer
    import sdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wait_two,
    input  logic last_byte,
    output logic busy,
    output logic rd_phase,
    output logic wr_phase,
    output logic done
);
    sdma_state_e state;
    logic [1:0]  align_left;
    logic        phase;

    // Advance the transfer state, the alignment count and the phase bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            align_left <= 2'd0;
            phase      <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_ALIGN;
                    align_left <= wait_two ? 2'd2 : 2'd1;
                    phase      <= 1'b0;
                end
                ST_ALIGN: begin
                    align_left <= align_left - 2'd1;
                    if (align_left == 2'd1) state <= ST_MOVE;
                end
                ST_MOVE: begin
                    phase <= ~phase;
                    if (phase && last_byte) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode bus phases from the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        rd_phase = (state == ST_MOVE) && !phase;
        wr_phase = (state == ST_MOVE) && phase;
    end

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase |=> wr_phase);
    // R3
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && !last_byte) |=> rd_phase);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !rd_phase && !wr_phase));
endmodule

// File: rtl/sdma_addr_gen.sv
// sdma_addr_gen: holds the source page, the byte offset and the read data.
// Assumes rd_phase and wr_phase are never high together.
module sdma_addr_gen #(
    parameter int PAGE_W   = 8,
    parameter int OFF_W    = 8,
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [PAGE_W-1:0]         page_in,
    input  logic                      rd_phase,
    input  logic                      wr_phase,
    input  logic [DATA_W-1:0]         rd_data,
    output logic [PAGE_W+OFF_W-1:0]   src_addr,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      last_byte
);
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  offset_q;
    logic [DATA_W-1:0] data_q;

    // Latch the page on start; step the offset after each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            offset_q <= '0;
        end else if (start) begin
            page_q   <= page_in;
            offset_q <= '0;
        end else if (wr_phase) begin
            offset_q <= offset_q + 1'b1;
        end
    end

    // Capture the byte fetched in a read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (rd_phase) data_q <= rd_data;
    end

    // Form the source address and the end-of-page flag.
    always_comb begin
        src_addr  = {page_q, offset_q};
        wr_data   = data_q;
        last_byte = (offset_q == OFF_W'(XFER_LEN - 1));
    end
endmodule

// File: rtl/sprite_dma_engine.sv
// sprite_dma_engine: copies one page into the sprite data port while the CPU
// is held. Assumes a same-cycle read response and XFER_LEN a power of two.
module sprite_dma_engine #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                XFER_LEN  = 256,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
    parameter logic [ADDR_W-1:0] SPR_PORT  = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              trig_rd_ack,
    output logic [DATA_W-1:0] trig_rdata,
    output logic              cpu_run,
    output logic              dma_rd_en,
    output logic [ADDR_W-1:0] dma_rd_addr,
    input  logic [DATA_W-1:0] dma_rd_data,
    output logic              dma_wr_en,
    output logic [ADDR_W-1:0] dma_wr_addr,
    output logic [DATA_W-1:0] dma_wr_data,
    output logic              xfer_done
);
    localparam int OFF_W  = $clog2(XFER_LEN);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic busy, rd_phase, wr_phase, last_byte, odd, start;
    logic [ADDR_W-1:0] src_addr;
    logic [DATA_W-1:0] wr_data;

    // Decode the trigger write and the trigger read.
    always_comb begin
        start       = cpu_wr_en && (cpu_addr == TRIG_ADDR) && !busy;
        trig_rd_ack = cpu_rd_en && (cpu_addr == TRIG_ADDR);
        trig_rdata  = '0;
    end

    sdma_parity u_parity (
        .clk(clk), .rst_n(rst_n), .cpu_run(cpu_run), .odd(odd)
    );

    sdma_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_two(odd),
        .last_byte(last_byte), .busy(busy), .rd_phase(rd_phase),
        .wr_phase(wr_phase), .done(xfer_done)
    );

    sdma_addr_gen #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start),
        .page_in(cpu_wdata[PAGE_W-1:0]), .rd_phase(rd_phase),
        .wr_phase(wr_phase), .rd_data(dma_rd_data), .src_addr(src_addr),
        .wr_data(wr_data), .last_byte(last_byte)
    );

    // Drive the bus-master outputs and the CPU enable.
    always_comb begin
        cpu_run     = !busy;
        dma_rd_en   = rd_phase;
        dma_rd_addr = rd_phase ? src_addr : '0;
        dma_wr_en   = wr_phase;
        dma_wr_addr = wr_phase ? SPR_PORT : '0;
        dma_wr_data = wr_data;
    end

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_rd_en && dma_wr_en));
    // R5
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_en |-> ($past(dma_rd_en) && dma_wr_data == $past(dma_rd_data)));
    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_en && $past(dma_wr_en)) |-> dma_rd_addr == $past(dma_rd_addr, 2) + 1'b1);
    // R7
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ($past(dma_wr_en) && cpu_run));
endmodule

// File: tb/tb_sprite_dma_engine.sv
`timescale 1ns/100ps
module tb_sprite_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0, cpu_rd_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        trig_rd_ack, cpu_run, dma_rd_en, dma_wr_en, xfer_done;
    logic [7:0]  trig_rdata, dma_rd_data, dma_wr_data;
    logic [15:0] dma_rd_addr, dma_wr_addr;

    int n_checks = 0, n_fail = 0;
    bit par_b = 1'b0;
    bit saw_w1 = 1'b0, saw_w2 = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    assign dma_rd_data = memf(dma_rd_addr);

    // Reference count of CPU-run cycles (parity only).
    always @(posedge clk) begin
        if (!rst_n)       par_b <= 1'b0;
        else if (cpu_run) par_b <= ~par_b;
    end

    sprite_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .trig_rd_ack(trig_rd_ack),
        .trig_rdata(trig_rdata), .cpu_run(cpu_run), .dma_rd_en(dma_rd_en),
        .dma_rd_addr(dma_rd_addr), .dma_rd_data(dma_rd_data),
        .dma_wr_en(dma_wr_en), .dma_wr_addr(dma_wr_addr),
        .dma_wr_data(dma_wr_data), .xfer_done(xfer_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        check(cpu_run && !dma_rd_en && !dma_wr_en && !xfer_done, tag,
              {cpu_run, dma_rd_en, dma_wr_en, xfer_done}, 4'b1000);
    endtask

    // R10: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_check("R10 reset state");
    endtask

    // R9: reads of the trigger address
    task automatic t_read();
        @(negedge clk);
        cpu_rd_en = 1'b1; cpu_addr = 16'h4014;
        #0.5;
        check(trig_rd_ack && trig_rdata == 8'h00, "R9 trigger read", {trig_rd_ack, trig_rdata}, 9'h100);
        @(negedge clk);
        cpu_addr = 16'h4015;
        #0.5;
        check(!trig_rd_ack, "R9 other address read", trig_rd_ack, 0);
        @(negedge clk);
        cpu_rd_en = 1'b0;
        idle_check("R9 read starts nothing");
    endtask

    task automatic to_parity(input bit want);
        while (par_b != want) @(negedge clk);
    endtask

    // R1-style full copy; hold keeps writing the trigger with alt page (R8)
    task automatic t_xfer(input logic [7:0] page, input bit hold, input logic [7:0] alt, input string tag);
        int w, first_rd, n_wr, b_seq, b_addr, b_data, b_run, b_done;
        @(negedge clk);
        w = par_b ? 2 : 1;
        cpu_wr_en = 1'b1; cpu_addr = 16'h4014; cpu_wdata = page;
        first_rd = -1; n_wr = 0; b_seq = 0; b_addr = 0; b_data = 0; b_run = 0; b_done = 0;
        for (int k = 1; k <= w + 513; k++) begin
            @(negedge clk);
            if (!hold && k == 1) cpu_wr_en = 1'b0;
            if (hold) cpu_wdata = alt;
            if (k == w + 512) cpu_wr_en = 1'b0;
            if (dma_rd_en && first_rd < 0) first_rd = k;
            if (dma_wr_en) n_wr++;
            if (k <= w + 512) begin
                if (cpu_run) b_run++;
                if (xfer_done) b_done++;
            end
            if (k <= w) begin
                if (dma_rd_en || dma_wr_en) b_seq++;
            end else if (k <= w + 512) begin
                int j;
                logic [7:0] off;
                j = k - w - 1;
                off = 8'(j / 2);
                if (j % 2 == 0) begin
                    if (!dma_rd_en || dma_wr_en) b_seq++;
                    if (dma_rd_addr != {page, off}) b_addr++;
                end else begin
                    if (!dma_wr_en || dma_rd_en) b_seq++;
                    if (dma_wr_addr != 16'h2004 || dma_wr_data != memf({page, off})) b_data++;
                end
            end else begin
                check(xfer_done, {"R7 done pulse ", tag}, xfer_done, 1);
                check(cpu_run && !dma_rd_en && !dma_wr_en, {"R6 run restored ", tag},
                      {cpu_run, dma_rd_en, dma_wr_en}, 3'b100);
            end
        end
        if (w == 1) saw_w1 = 1'b1; else saw_w2 = 1'b1;
        check(first_rd == w + 1, {"R2 alignment wait ", tag}, first_rd - 1, w);
        check(b_seq == 0 && n_wr == 256, {"R3 read/write pairs ", tag}, n_wr, 256);
        check(b_addr == 0, {hold ? "R8 page kept " : "R4 source addresses ", tag}, b_addr, 0);
        check(b_data == 0, {"R5 write port and data ", tag}, b_data, 0);
        check(b_run == 0, {"R6 cpu held ", tag}, b_run, 0);
        check(b_done == 0, {"R7 no early done ", tag}, b_done, 0);
        @(negedge clk);
        idle_check({"R7 done drops ", tag});
    endtask

    // R10: reset in the middle of a copy, then a clean copy
    task automatic t_mid_reset();
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = 16'h4014; cpu_wdata = 8'h22;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        repeat (20) @(negedge clk);
        check(!cpu_run, "R6 held mid copy", cpu_run, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle_check("R10 reset mid copy");
        @(negedge clk);
        idle_check("R10 stays idle");
    endtask

    initial begin
        t_reset();
        t_read();
        to_parity(1'b0);
        t_xfer(8'h03, 1'b0, 8'h00, "A");
        to_parity(1'b1);
        t_xfer(8'h7F, 1'b0, 8'h00, "B");
        to_parity(1'b0);
        t_xfer(8'hC0, 1'b1, 8'h11, "C");
        t_mid_reset();
        t_xfer(8'hFF, 1'b0, 8'h00, "D");
        check(saw_w1 && saw_w2, "R2 both wait lengths seen", {saw_w1, saw_w2}, 2'b11);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule